// File: doc/BRIEF.md
# Byte-Wide Many-Time-Programmable Memory Device Model

This block is a synthesizable, clocked model of a byte-wide non-volatile memory that is erased and reprogrammed from an external programmer. On every clock edge it samples its control pins and picks an operating mode from them. The pins are chip select, output gate and program strobe, plus two logic flags. One flag says the supply pin is at programming voltage. The other says address line 9 is held at its high-voltage level. From that mode the block serves reads, holds its outputs off, programs a single byte, clears the whole array to ones, or returns a two-byte identification pair.

Programming behaves like real floating-gate cells. A program pulse can only clear bits, so the stored byte becomes the AND of the old byte and the new data. The only way back to ones is a chip erase, which sets every byte to FFh. The output is an 8-bit bus with a separate enable, so a surrounding model can build a tri-state pad. The array depth comes from an address-width parameter, and the density variant picks the device identification code.

Top module: `mtp_rom_model`

## Requirements
- R1: With chip select low, output gate low, supply flag low and A9 flag low, the byte at `addr` appears on `dout` with `dout_en` high on the clock edge after the inputs are sampled.
- R2: With chip select high, `dout_en` is low on the next edge, whatever the other pins are.
- R3: With chip select low and output gate high, `dout_en` is low on the next edge, and `dout` reads 00h whenever `dout_en` is low.
- R4: A program happens only when a falling strobe (`pgm_n` sampled high, then sampled low) is seen with chip select low, output gate high, supply flag high and A9 flag low. A falling strobe in any mode where the supply flag is low writes nothing.
- R5: With chip select high and the supply flag high, strobe pulses neither program nor erase, whether the A9 flag is high or low.
- R6: A program stores the bitwise AND of the old byte and `din`, so no bit goes from 0 to 1. For example, 5Ah followed by F0h leaves 50h.
- R7: A falling strobe with chip select low, output gate high, supply flag high and A9 flag high sets every byte to FFh, whatever `addr` and `din` hold.
- R8: With chip select low, output gate low, supply flag low and A9 flag high, the block drives `dout_en` high. `dout` is BFh when all address bits other than bit 0 and bit 9 are zero and bit 0 is 0. It is the device code when those bits are zero and bit 0 is 1. It is 00h when any of those other bits is set.
- R9: The device code is A4h, A5h or A6h for `VARIANT` 0, 1 or 2.
- R10: Reset fills the array with FFh, disables the outputs and records the strobe as high.
- R11: With chip select low, output gate low and supply flag high, the outputs are disabled and strobe pulses write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| pgm_n | input | 1 | Program/erase strobe, active on its falling edge |
| vpp_hi | input | 1 | Supply pin at programming voltage |
| a9_hi | input | 1 | Address line 9 at high voltage |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Program data |
| dout | output | 8 | Read or identification byte |
| dout_en | output | 1 | Output driver enable |

## Verification
The bench builds the block with `ADDR_W` = 10 and `VARIANT` = 2. With a 10-bit address, bit 9 is a real address line. That lets the bench show two things in identification mode: bit 9 is ignored there, while a high bit elsewhere gives 00h. It also lets a plain read reach an address with bit 9 set, and lets the bench program the very last byte. With `VARIANT` = 2, the device code is A6h, which cannot be mistaken for the codes of the other densities.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

  typedef enum logic [2:0] {
    M_STANDBY, M_INHIBIT, M_OUTDIS, M_READ,
    M_IDENT, M_PROG, M_ERASE, M_BLOCKED
  } mtp_mode_e;

  localparam logic [7:0] MFR_CODE = 8'hBF;

  // Mode from pin levels; chip select dominates, then the supply flag.
  function automatic mtp_mode_e decode_mode(input logic ce_n, input logic oe_n,
                                            input logic vpp_hi, input logic a9_hi);
    if (ce_n)             return vpp_hi ? M_INHIBIT : M_STANDBY;
    if (vpp_hi && oe_n)   return a9_hi ? M_ERASE : M_PROG;
    if (vpp_hi)           return M_BLOCKED;
    if (oe_n)             return M_OUTDIS;
    return a9_hi ? M_IDENT : M_READ;
  endfunction

  function automatic logic [7:0] device_code(input int variant);
    case (variant)
      0:       return 8'hA4;
      1:       return 8'hA5;
      default: return 8'hA6;
    endcase
  endfunction

  // Cells can only be cleared by programming.
  function automatic logic [7:0] prog_merge(input logic [7:0] old_b, input logic [7:0] new_b);
    return old_b & new_b;
  endfunction

endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
  import mtp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ce_n,
  input  logic      oe_n,
  input  logic      pgm_n,
  input  logic      vpp_hi,
  input  logic      a9_hi,
  output mtp_mode_e mode,
  output logic      prog_fire,
  output logic      erase_fire
);

  logic pgm_q;
  logic strobe_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pgm_q <= 1'b1;
    else        pgm_q <= pgm_n;
  end

  assign mode        = decode_mode(ce_n, oe_n, vpp_hi, a9_hi);
  assign strobe_fall = pgm_q & ~pgm_n;
  assign prog_fire   = strobe_fall && (mode == M_PROG);
  assign erase_fire  = strobe_fall && (mode == M_ERASE);

  AST_INHIBIT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!prog_fire && !erase_fire)); // R5
  AST_LOW_SUPPLY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !vpp_hi |-> (!prog_fire && !erase_fire)); // R4
  AST_GATE_LOW_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n) |-> (!prog_fire && !erase_fire)); // R11

endmodule

// File: rtl/mtp_array.sv
module mtp_array
  import mtp_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_fire,
  input  logic              erase_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_fire) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_fire) begin
      mem[addr] <= prog_merge(mem[addr], din);
    end
  end

  assign rd_data = mem[addr];

  AST_PROG_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_fire |=> (addr != $past(addr)) || ((rd_data & ~$past(rd_data)) == 8'h00)); // R6
  AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |=> (mem[0] == 8'hFF) && (mem[DEPTH-1] == 8'hFF)); // R7
  AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_fire && erase_fire)); // R4

endmodule

// File: rtl/mtp_out_stage.sv
module mtp_out_stage
  import mtp_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int VARIANT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mtp_mode_e         mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        rd_data,
  output logic [7:0]        dout,
  output logic              dout_en
);

  localparam logic [7:0] DEV_CODE = device_code(VARIANT);

  // Identification byte: only bit 0 selects; bit 9 is the high-voltage line.
  function automatic logic [7:0] ident_value(input logic [ADDR_W-1:0] a);
    logic clean;
    clean = 1'b1;
    for (int i = 1; i < ADDR_W; i++)
      if (i != 9 && a[i]) clean = 1'b0;
    if (!clean) return 8'h00;
    return a[0] ? DEV_CODE : MFR_CODE;
  endfunction

  logic [7:0] id_byte;
  assign id_byte = ident_value(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= 8'h00;
      dout_en <= 1'b0;
    end else begin
      case (mode)
        M_READ:  begin dout <= rd_data; dout_en <= 1'b1; end
        M_IDENT: begin dout <= id_byte; dout_en <= 1'b1; end
        default: begin dout <= 8'h00;   dout_en <= 1'b0; end
      endcase
    end
  end

  AST_ID_MFR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDENT && addr == '0) |=> (dout == 8'hBF) && dout_en); // R8
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == 8'h00)); // R3

endmodule

// File: rtl/mtp_rom_model.sv
module mtp_rom_model
  import mtp_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int VARIANT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hi,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);

  mtp_mode_e  mode;
  logic       prog_fire;
  logic       erase_fire;
  logic [7:0] rd_data;

  mtp_mode_decode u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .mode(mode),
    .prog_fire(prog_fire), .erase_fire(erase_fire)
  );

  mtp_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .prog_fire(prog_fire), .erase_fire(erase_fire),
    .addr(addr), .din(din), .rd_data(rd_data)
  );

  mtp_out_stage #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .addr(addr), .rd_data(rd_data),
    .dout(dout), .dout_en(dout_en)
  );

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dout_en); // R2
  AST_OUTDIS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |=> !dout_en); // R3
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_hi) |=> dout_en); // R1

endmodule

// File: tb/mtp_rom_model_test.sv
module mtp_rom_model_test;

  localparam int ADDR_W  = 10;
  localparam int VARIANT = 2;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam logic [7:0] EXP_DEV = 8'hA4 + 8'(VARIANT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hi = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic dout_en;

  always #2 clk = ~clk;

  mtp_rom_model #(.ADDR_W(ADDR_W), .VARIANT(VARIANT)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hi(a9_hi), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  typedef struct {
    logic       en;
    logic [7:0] data;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] ref_mem [DEPTH];

  // Monitor: one expected item is due at the falling edge after it was queued.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        checks++;
        if (dout_en !== it.en || (it.en && dout !== it.data) || (!it.en && dout !== 8'h00)) begin
          fails++;
          $display("FAIL %s: got en=%0b data=%02h, expected en=%0b data=%02h",
                   it.tag, dout_en, dout, it.en, it.en ? it.data : 8'h00);
        end
      end
    end
  end

  task automatic drive(input logic c, input logic o, input logic p, input logic vh,
                       input logic a9, input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; pgm_n = p; vpp_hi = vh; a9_hi = a9; addr = a; din = d;
  endtask

  task automatic expect_out(input logic en, input logic [7:0] data, input string tag);
    @(posedge clk);
    #1;
    sb.push_back('{en, data, tag});
  endtask

  task automatic read_chk(input logic [ADDR_W-1:0] a, input string tag);
    drive(0, 0, 1, 0, 0, a, 8'h00);
    expect_out(1'b1, ref_mem[a], tag);
  endtask

  task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    drive(0, 1, 1, 1, 0, a, d);
    expect_out(1'b0, 8'h00, "R3 outputs off while programming");
    drive(0, 1, 0, 1, 0, a, d);
    drive(0, 1, 1, 1, 0, a, d);
    drive(1, 1, 1, 0, 0, a, d);
    ref_mem[a] = ref_mem[a] & d;
  endtask

  task automatic erase(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    drive(0, 1, 1, 1, 1, a, d);
    drive(0, 1, 0, 1, 1, a, d);
    drive(0, 1, 1, 1, 1, a, d);
    drive(1, 1, 1, 0, 0, a, d);
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
  endtask

  task automatic pulse_in(input logic c, input logic o, input logic vh, input logic a9,
                          input logic [ADDR_W-1:0] a, input logic [7:0] d);
    drive(c, o, 1, vh, a9, a, d);
    drive(c, o, 0, vh, a9, a, d);
    drive(c, o, 1, vh, a9, a, d);
    drive(1, 1, 1, 0, 0, a, d);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 / R2: reset state, standby
    drive(1, 0, 1, 0, 0, 10'd3, 8'h00);
    expect_out(1'b0, 8'h00, "R10 R2 standby after reset");
    read_chk(10'd0, "R10 erased after reset low");
    read_chk(10'(DEPTH-1), "R10 erased after reset top");

    // R6: program and AND semantics
    prog(10'd3, 8'h5A);
    read_chk(10'd3, "R6 first program 5A");
    prog(10'd3, 8'hF0);
    read_chk(10'd3, "R6 AND gives 50");
    prog(10'(DEPTH-1), 8'h3C);
    read_chk(10'(DEPTH-1), "R4 program top address");
    prog(10'h205, 8'h81);
    read_chk(10'h205, "R1 read with bit 9 set");
    read_chk(10'd4, "R1 neighbour untouched");

    // R2 / R3 output disable
    drive(0, 1, 1, 0, 0, 10'd3, 8'h00);
    expect_out(1'b0, 8'h00, "R3 output disable");
    drive(1, 0, 1, 0, 1, 10'd3, 8'h00);
    expect_out(1'b0, 8'h00, "R2 standby with A9 flag");

    // R4: strobe with low supply writes nothing
    pulse_in(0, 1, 0, 0, 10'd3, 8'h00);
    read_chk(10'd3, "R4 low-supply strobe ignored");
    // R5: inhibit, program and erase
    pulse_in(1, 1, 1, 0, 10'd3, 8'h00);
    read_chk(10'd3, "R5 inhibit blocks program");
    pulse_in(1, 1, 1, 1, 10'd3, 8'h00);
    read_chk(10'(DEPTH-1), "R5 inhibit blocks erase");
    // R11: gate low with supply high
    drive(0, 0, 1, 1, 0, 10'd3, 8'h00);
    expect_out(1'b0, 8'h00, "R11 outputs off");
    pulse_in(0, 0, 1, 0, 10'd3, 8'h00);
    read_chk(10'd3, "R11 strobe ignored");

    // R8 / R9 identification
    drive(0, 0, 1, 0, 1, 10'd0, 8'h00);
    expect_out(1'b1, 8'hBF, "R8 manufacturer byte");
    drive(0, 0, 1, 0, 1, 10'd1, 8'h00);
    expect_out(1'b1, EXP_DEV, "R9 device code");
    drive(0, 0, 1, 0, 1, 10'h201, 8'h00);
    expect_out(1'b1, EXP_DEV, "R8 bit 9 ignored");
    drive(0, 0, 1, 0, 1, 10'h020, 8'h00);
    expect_out(1'b1, 8'h00, "R8 other bit set gives 00");

    // R7 erase, address and data don't-care
    erase(10'h155, 8'h00);
    read_chk(10'd3, "R7 erased programmed byte");
    read_chk(10'(DEPTH-1), "R7 erased top");
    read_chk(10'h205, "R7 erased bit9 address");
    prog(10'd3, 8'h0F);
    read_chk(10'd3, "R6 program after erase");

    drive(1, 1, 1, 0, 0, 10'd0, 8'h00);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule